// File: doc/BRIEF.md
# Frequency-Adaptive Quarter-Period Delay

This block produces the quadrature (beta) component of a single-phase voltage. It delays the sampled alpha stream by one quarter of the grid period. The required delay is `FS_HZ / (4 * f_grid)` samples, and this is rarely a whole number. The block therefore splits the delay into two parts. A whole-sample part `P` is read from a circular history of past samples. The remaining fraction `F` is filled in by a four-tap third-order Lagrange interpolator across the samples at delays `P`, `P+1`, `P+2` and `P+3`. With this split, the quadrature signal carries no phase error from rounding the delay to a whole sample.

The grid-frequency estimate is given as an unsigned fixed-point word with a load strobe. After each load, a sequential divider computes the delay in Q.16 samples. A single shared multiplier then works through the four interpolation weights. The new whole-sample delay and the new weights replace the active set together, in one step. Alpha samples arrive with a strobe. Each sample yields one beta sample, which also comes with a strobe.

Top module: `qd_quarter_delay`

## Requirements
- R1: After reset, `beta_o` is 0 and `beta_vld_o` is low. Until the first frequency load, the delay is `P = FS_HZ/(4*NOM_HZ)` (50 with defaults) and `F = 0`. The sample history starts out all zero.
- R2: Every cycle with `smp_vld_i` high gives exactly one cycle of `beta_vld_o` high, two rising edges later. `beta_o` holds its value in cycles where `beta_vld_o` is low.
- R3: `freq_i` is an unsigned Q8.16 frequency in Hz and is captured when `freq_vld_i` is high. The delay is `D = floor(FS_HZ * 2^30 / freq_i)` in Q.16 samples, with `P = D >> 16` and `F = D[15:0]`.
- R4: When `F = 0`, each beta sample equals exactly the alpha sample `P` samples earlier. The active weights are then exactly 1.0, 0, 0, 0.
- R5: When `F != 0`, each beta sample is the rounded sum `d0*x[k-P] + d1*x[k-P-1] + d2*x[k-P-2] + d3*x[k-P-3]`, within 4 LSB. The weights are d0 = (1-F)(2-F)(3-F)/6, d1 = F(2-F)(3-F)/2, d2 = -F(1-F)(3-F)/2 and d3 = F(1-F)(2-F)/6.
- R6: A new delay and its weights take effect together no later than 64 cycles after the `freq_vld_i` strobe.
- R7: If `P` would exceed `DEPTH-4` (124 with defaults), or if `freq_i` is 0, then `P` is set to `DEPTH-4` and `F` to 0.
- R8: The four active weights add up to 1.0 within 16 LSB of Q2.16. A constant input therefore passes through unchanged in the steady state.
- R9: A result that falls outside the signed 16-bit range saturates to 32767 or -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Alpha sample strobe |
| smp_i | input | 16 | Alpha sample, signed |
| freq_vld_i | input | 1 | Frequency load strobe |
| freq_i | input | FREQ_W | Grid frequency, unsigned Q8.16 Hz |
| beta_vld_o | output | 1 | Beta sample strobe |
| beta_o | output | 16 | Beta sample, signed |

## Verification
Some corner cases only appear when the frequency word yields a very specific delay. These are a Q.16 delay with an all-zero fraction, a delay past the end of the history, and a zero frequency word. The stimulus reaches them with frequency words whose quotients are known in advance: 62.5 Hz gives exactly 40 samples, while 10 Hz and 0 Hz both force the clamp. Saturation needs full-scale samples lined up against the sign pattern of the weights. A full-scale pattern repeating every four samples is sent at a delay near 50.5, so every alignment of the taps occurs.

// File: rtl/qd_pkg.sv
package qd_pkg;
  localparam int SMP_W  = 16;
  localparam int COEF_W = 20;
  localparam int FRAC_W = 16;
  localparam int NTAP   = 4;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic [FRAC_W-1:0]        frac_t;
endpackage

// File: rtl/qd_delay_calc.sv
module qd_delay_calc
  import qd_pkg::*;
#(
  parameter int FS_HZ  = 10000,
  parameter int FREQ_W = 24,
  parameter int PW     = 7,
  parameter int P_MAX  = 124
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic              done_o,
  output logic [PW-1:0]     p_o,
  output frac_t             f_o
);
  localparam int NUM_W = $clog2(FS_HZ + 1) + 30;
  localparam int CNT_W = $clog2(NUM_W);
  localparam int INT_W = NUM_W - FRAC_W;
  localparam logic [NUM_W-1:0] NUM = NUM_W'(FS_HZ) << 30;

  logic              busy_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FREQ_W-1:0] rem_q, div_q;
  logic [NUM_W-1:0]  quo_q;
  logic [FREQ_W:0]   rem_sh, diff;
  logic              ge;

  // restoring division, one quotient bit per cycle
  always_comb begin
    rem_sh = {rem_q, NUM[cnt_q]};
    diff   = rem_sh - {1'b0, div_q};
    ge     = !diff[FREQ_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      quo_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= CNT_W'(NUM_W - 1);
      rem_q  <= '0;
      div_q  <= freq_i;
      quo_q  <= '0;
    end else if (busy_q) begin
      rem_q <= ge ? diff[FREQ_W-1:0] : rem_sh[FREQ_W-1:0];
      quo_q <= {quo_q[NUM_W-2:0], ge};
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  logic [INT_W-1:0] int_part;
  logic             over;

  always_comb begin
    int_part = quo_q[NUM_W-1:FRAC_W];
    over     = (int_part > INT_W'(P_MAX)) || (div_q == '0);
    p_o      = over ? PW'(P_MAX) : int_part[PW-1:0];
    f_o      = over ? '0 : quo_q[FRAC_W-1:0];
  end

  assign done_o = done_q;
endmodule

// File: rtl/qd_coef_gen.sv
module qd_coef_gen
  import qd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  frac_t            f_i,
  output logic             done_o,
  output coef_t [NTAP-1:0] coef_o
);
  localparam int ONE     = 1 << FRAC_W;
  localparam int LAST_ST = 6;

  logic             busy_q, done_q;
  logic [2:0]       step_q;
  coef_t            fx_q, p12_q, p23_q, p13_q;
  coef_t [NTAP-1:0] coef_q;
  coef_t            am1, am2, am3, op_a, op_b, ps;
  logic signed [2*COEF_W-1:0] prod;

  assign am1 = fx_q - coef_t'(ONE);
  assign am2 = fx_q - coef_t'(2 * ONE);
  assign am3 = fx_q - coef_t'(3 * ONE);

  // one shared multiplier, operands picked by step
  always_comb begin
    case (step_q)
      3'd0:    begin op_a = am1;   op_b = am2;   end
      3'd1:    begin op_a = am2;   op_b = am3;   end
      3'd2:    begin op_a = am1;   op_b = am3;   end
      3'd3:    begin op_a = p12_q; op_b = am3;   end
      3'd4:    begin op_a = fx_q;  op_b = p23_q; end
      3'd5:    begin op_a = fx_q;  op_b = p13_q; end
      default: begin op_a = fx_q;  op_b = p12_q; end
    endcase
    prod = op_a * op_b;
    ps   = coef_t'(prod >>> FRAC_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      fx_q   <= '0;
      p12_q  <= '0;
      p23_q  <= '0;
      p13_q  <= '0;
      coef_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      step_q <= '0;
      fx_q   <= coef_t'({4'b0000, f_i});
    end else if (busy_q) begin
      case (step_q)
        3'd0:    p12_q <= ps;
        3'd1:    p23_q <= ps;
        3'd2:    p13_q <= ps;
        3'd3:    coef_q[0] <= coef_t'(-ps / 6);
        3'd4:    coef_q[1] <= coef_t'(ps / 2);
        3'd5:    coef_q[2] <= coef_t'(-ps / 2);
        default: coef_q[3] <= coef_t'(ps / 6);
      endcase
      if (step_q == 3'(LAST_ST)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign coef_o = coef_q;
endmodule

// File: rtl/qd_hist.sv
module qd_hist
  import qd_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  smp_t            din_i,
  input  logic [AW-1:0]   p_i,
  output smp_t [NTAP-1:0] tap_o
);
  smp_t          mem_q [DEPTH];
  logic [AW-1:0] wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wptr_q <= '0;
    end else if (wr_i) begin
      mem_q[wptr_q] <= din_i;
      wptr_q        <= wptr_q + 1'b1;
    end
  end

  // newest sample sits at wptr_q-1; tap l reads delay P+l
  for (genvar l = 0; l < NTAP; l++) begin : g_tap
    assign tap_o[l] = mem_q[wptr_q - AW'(1) - p_i - AW'(l)];
  end
endmodule

// File: rtl/qd_fir.sv
module qd_fir
  import qd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  smp_t  [NTAP-1:0] tap_i,
  input  coef_t [NTAP-1:0] coef_i,
  output smp_t             beta_o,
  output logic             vld_o
);
  localparam int ACC_W = SMP_W + COEF_W + 2;
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;
  localparam logic signed [ACC_W-1:0] RND    = ACC_W'(1 << (FRAC_W - 1));

  logic signed [ACC_W-1:0] prod [NTAP];

  for (genvar l = 0; l < NTAP; l++) begin : g_mac
    smp_t  tv;
    coef_t cv;
    assign tv      = tap_i[l];
    assign cv      = coef_i[l];
    assign prod[l] = tv * cv;
  end

  logic signed [ACC_W-1:0] acc, sh;
  smp_t                    sat;

  always_comb begin
    acc = RND;
    for (int l = 0; l < NTAP; l++) acc = acc + prod[l];
    sh = acc >>> FRAC_W;
    if (sh > SAT_HI)      sat = smp_t'(SAT_HI);
    else if (sh < SAT_LO) sat = smp_t'(SAT_LO);
    else                  sat = sh[SMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beta_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= en_i;
      if (en_i) beta_o <= sat;
    end
  end
endmodule

// File: rtl/qd_quarter_delay.sv
module qd_quarter_delay
  import qd_pkg::*;
#(
  parameter int FS_HZ  = 10000,
  parameter int NOM_HZ = 50,
  parameter int FREQ_W = 24,
  parameter int DEPTH  = 128
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic                    freq_vld_i,
  input  logic [FREQ_W-1:0]       freq_i,
  output logic                    beta_vld_o,
  output logic signed [SMP_W-1:0] beta_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int P_MAX = DEPTH - NTAP;
  localparam int P_NOM = FS_HZ / (4 * NOM_HZ);
  localparam int ONE   = 1 << FRAC_W;

  logic             calc_done, coef_done, rd_vld_q;
  logic [AW-1:0]    calc_p, p_pend_q, p_act_q;
  frac_t            calc_f, f_pend_q, f_act_q;
  coef_t [NTAP-1:0] coef_new, coef_act_q;
  smp_t  [NTAP-1:0] taps;
  smp_t             beta_w;

  qd_delay_calc #(
    .FS_HZ (FS_HZ),
    .FREQ_W(FREQ_W),
    .PW    (AW),
    .P_MAX (P_MAX)
  ) u_calc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(freq_vld_i),
    .freq_i (freq_i),
    .done_o (calc_done),
    .p_o    (calc_p),
    .f_o    (calc_f)
  );

  qd_coef_gen u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(calc_done),
    .f_i    (calc_f),
    .done_o (coef_done),
    .coef_o (coef_new)
  );

  // pending set waits for weights; then delay and weights swap together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_pend_q   <= AW'(P_NOM);
      f_pend_q   <= '0;
      p_act_q    <= AW'(P_NOM);
      f_act_q    <= '0;
      coef_act_q <= '0;
      coef_act_q[0] <= coef_t'(ONE);
      rd_vld_q   <= 1'b0;
    end else begin
      rd_vld_q <= smp_vld_i;
      if (calc_done) begin
        p_pend_q <= calc_p;
        f_pend_q <= calc_f;
      end
      if (coef_done) begin
        p_act_q    <= p_pend_q;
        f_act_q    <= f_pend_q;
        coef_act_q <= coef_new;
      end
    end
  end

  qd_hist #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_hist (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (smp_vld_i),
    .din_i (smp_i),
    .p_i   (p_act_q),
    .tap_o (taps)
  );

  qd_fir u_fir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (rd_vld_q),
    .tap_i (taps),
    .coef_i(coef_act_q),
    .beta_o(beta_w),
    .vld_o (beta_vld_o)
  );

  assign beta_o = beta_w;
endmodule

// File: rtl/qd_quarter_delay_chk.sv
module qd_quarter_delay_chk
  import qd_pkg::*;
#(
  parameter int P_MAX = 124,
  parameter int AW    = 7
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     smp_vld_i,
  input logic                     beta_vld_o,
  input logic signed [SMP_W-1:0]  beta_o,
  input logic [AW-1:0]            p_act,
  input frac_t                    f_act,
  input logic [NTAP*COEF_W-1:0]   coef_act
);
  localparam int ONE = 1 << FRAC_W;

  coef_t c0, c1, c2, c3;
  int    csum;

  assign c0   = coef_act[0*COEF_W +: COEF_W];
  assign c1   = coef_act[1*COEF_W +: COEF_W];
  assign c2   = coef_act[2*COEF_W +: COEF_W];
  assign c3   = coef_act[3*COEF_W +: COEF_W];
  assign csum = int'(c0) + int'(c1) + int'(c2) + int'(c3);

  p_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beta_vld_o == $past(smp_vld_i, 2));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beta_vld_o |-> $stable(beta_o));

  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_act <= AW'(P_MAX));

  p_unity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csum - ONE <= 16) && (ONE - csum <= 16));

  p_exact_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_act == '0) |-> (int'(c0) == ONE && c1 == '0 && c2 == '0 && c3 == '0));
endmodule

bind qd_quarter_delay qd_quarter_delay_chk #(
  .P_MAX(P_MAX),
  .AW   (AW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_vld_i (smp_vld_i),
  .beta_vld_o(beta_vld_o),
  .beta_o    (beta_o),
  .p_act     (p_act_q),
  .f_act     (f_act_q),
  .coef_act  (coef_act_q)
);

// File: tb/qd_quarter_delay_tb.sv
module qd_quarter_delay_tb;
  localparam int CLK_P  = 10;
  localparam int FS     = 10000;
  localparam int P_LIM  = 124;
  localparam int FREQ_W = 24;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                smp_vld = 1'b0;
  logic signed [15:0]  smp = '0;
  logic                freq_vld = 1'b0;
  logic [FREQ_W-1:0]   freq = '0;
  logic                beta_vld;
  logic signed [15:0]  beta;

  int vectors = 0;
  int fails   = 0;
  int m_p     = 50;
  int m_f     = 0;
  int hist_m[$];
  int exp_q[$];
  int tol_q[$];
  string req_q[$];

  always #(CLK_P/2) clk = ~clk;

  qd_quarter_delay u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .smp_vld_i (smp_vld),
    .smp_i     (smp),
    .freq_vld_i(freq_vld),
    .freq_i    (freq),
    .beta_vld_o(beta_vld),
    .beta_o    (beta)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R3/R7 model of delay split
  task automatic model_freq(input longint fr);
    longint d, ip;
    if (fr == 0) begin
      m_p = P_LIM; m_f = 0;
    end else begin
      d  = (longint'(FS) << 30) / fr;
      ip = d >> 16;
      if (ip > P_LIM) begin m_p = P_LIM; m_f = 0; end
      else begin m_p = int'(ip); m_f = int'(d & 65535); end
    end
  endtask

  task automatic apply_freq(input int fr);
    @(negedge clk);
    freq = FREQ_W'(fr);
    freq_vld = 1'b1;
    @(negedge clk);
    freq_vld = 1'b0;
    repeat (64) @(negedge clk);  // R6 window
    model_freq(longint'(fr));
  endtask

  task automatic send(input int x, input string req);
    int n, v, idx, e;
    real f, acc;
    real d[4];
    n = hist_m.size();
    hist_m.push_back(x);
    f = real'(m_f) / 65536.0;
    d[0] = (1.0 - f) * (2.0 - f) * (3.0 - f) / 6.0;
    d[1] = f * (2.0 - f) * (3.0 - f) / 2.0;
    d[2] = -f * (1.0 - f) * (3.0 - f) / 2.0;
    d[3] = f * (1.0 - f) * (2.0 - f) / 6.0;
    acc = 0.0;
    for (int l = 0; l < 4; l++) begin
      idx = n - m_p - l;
      v = (idx >= 0) ? hist_m[idx] : 0;
      acc += d[l] * real'(v);
    end
    e = (acc >= 0.0) ? $rtoi(acc + 0.5) : -$rtoi(-acc + 0.5);
    if (e > 32767) e = 32767;
    if (e < -32768) e = -32768;
    exp_q.push_back(e);
    tol_q.push_back((m_f == 0) ? 0 : 4);
    req_q.push_back(req);
    @(negedge clk);
    smp_vld = 1'b1;
    smp = 16'(x);
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && beta_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected strobe", int'(beta), 0);
      end else begin
        int e, t, df;
        string r;
        e = exp_q.pop_front();
        t = tol_q.pop_front();
        r = req_q.pop_front();
        df = int'(beta) - e;
        chk((df <= t) && (-df <= t), r, int'(beta), e);
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(beta == 16'sd0, "R1 beta after reset", int'(beta), 0);
    chk(beta_vld == 1'b0, "R1 strobe after reset", int'(beta_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(beta_vld == 1'b0, "R1 idle strobe", int'(beta_vld), 0);

    // R1/R4: nominal delay 50, zero history
    for (int k = 0; k < 80; k++)
      send(int'($urandom_range(40000)) - 20000, (k < 50) ? "R1 zero history" : "R4 nominal");

    // R3/R4: 62.5 Hz gives exactly 40 samples
    apply_freq(62 * 65536 + 32768);
    send(1111, "R6 first after update");
    for (int k = 0; k < 60; k++) send(int'($urandom_range(40000)) - 20000, "R3 R4 delay 40");

    // R5: about 50.5 samples, sine input
    apply_freq(3244356);
    send(0, "R6 first after update");
    for (int k = 0; k < 120; k++)
      send($rtoi(20000.0 * $sin(6.283185307 * real'(k) / 200.0)), "R5 sine");

    // R9: full-scale pattern with period 4
    for (int k = 0; k < 40; k++)
      send(((k % 4) == 2) ? -32768 : 32767, "R9 saturation");

    // R5/R8: 55 Hz random then constant
    apply_freq(55 * 65536);
    for (int k = 0; k < 60; k++) send(int'($urandom_range(40000)) - 20000, "R5 55Hz");
    for (int k = 0; k < 70; k++) send(12345, "R8 dc gain");

    // R7: 10 Hz and zero frequency clamp
    apply_freq(10 * 65536);
    for (int k = 0; k < 140; k++) send(int'($urandom_range(40000)) - 20000, "R7 clamp 10Hz");
    apply_freq(0);
    for (int k = 0; k < 30; k++) send(int'($urandom_range(40000)) - 20000, "R7 clamp zero");

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all outputs seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule